// File: doc/BRIEF.md
# Interrupt Request Capture and Global Enable Gate

This block sits between a single interrupting device and a CPU sequence controller. It watches a raw, asynchronous request line and, depending on a two-bit sense selection, treats either a steady level or a transition as a request. The line is usually active-low, because several devices share it as a wired-OR line. A recognised request is held in a request latch. A global enable flip-flop gates that latch towards the sequence controller, and the result is the pending output.

The sequence controller raises the acknowledge strobe once the current instruction has finished and it has seen the pending output. An acknowledge that is taken clears the request latch and the global enable, and the block echoes it to the device as a device acknowledge. The global enable comes back only through an enable strobe or a return-from-interrupt strobe. Software therefore decides whether a handler may be interrupted again. A disable strobe or a CPU reset clears the enable.

Top module: `intr_req_gate`

## Requirements
- R1: During reset and afterwards, `pend_o` and `dev_ack_o` are 0 and the global enable is clear. No request is recognised until the synchronizer and the edge history have refilled since reset (three clock edges with the defaults). A line held steady at its idle value through reset therefore produces no request.
- R2: `sense_mode` selects how the raw line is read. 2'b00 is low level, 2'b01 is high level, 2'b10 is a falling edge and 2'b11 is a rising edge. With enable set, `pend_o` rises after the third rising clock edge following a change on `irq_raw`, and not after the second. That latency comes from two synchronizer flops plus the latch.
- R3: A recognised request stays latched after the raw line returns to its idle value, until an acknowledge is taken.
- R4: `pend_o` is the request latch ANDed with the global enable. A request recognised while the enable is clear is kept, and it appears on `pend_o` once the enable is set.
- R5: A disable strobe clears the global enable, so `pend_o` is 0 after the next clock edge.
- R6: An enable strobe or a return-from-interrupt strobe sets the global enable. If a clearing cause (disable strobe or taken acknowledge) occurs in the same cycle, the clear wins.
- R7: An acknowledge is taken only while `pend_o` is 1. `dev_ack_o` equals `ack_in` AND `pend_o` in the same cycle. An `ack_in` while `pend_o` is 0 leaves both the latch and the enable unchanged.
- R8: A taken acknowledge clears both the request latch and the global enable on the next clock edge.
- R9: In the level modes, if the level is still active when the acknowledge is taken, the latch is set again in that same cycle (the set wins over the clear). `pend_o` returns as soon as the enable is set again.
- R10: In the edge modes, a line that stays at its active value after a taken acknowledge does not set the latch again. A new edge is required.
- R11: A transition in the opposite direction (edge modes), and an inactive level (level modes), never set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | CPU reset, active low, asynchronous assert |
| irq_raw | input | 1 | Raw asynchronous request line from the device |
| sense_mode | input | 2 | Sense select: 00 low, 01 high, 10 falling, 11 rising |
| ei_strobe | input | 1 | Enable-interrupts instruction strobe |
| di_strobe | input | 1 | Disable-interrupts instruction strobe |
| reti_strobe | input | 1 | Return-from-interrupt strobe |
| ack_in | input | 1 | Acknowledge from the sequence controller |
| pend_o | output | 1 | Pending interrupt to the sequence controller |
| dev_ack_o | output | 1 | Acknowledge pulse back to the device |

## Verification
All four sense modes go through the same stimulus sequence, and expected values are derived from the mode bits: the active value and whether the mode is edge or level. Asserting the line separates the second-edge and third-edge samples, which pins the latency. Returning it to idle before the acknowledge separates latching from following the line. Acknowledging while the line is still active is the pattern that splits level modes from edge modes. Strobe pairs issued in one cycle, and an acknowledge given while nothing is pending, expose priority mistakes in the enable. A rising-mode run with the line high through reset shows whether the arming window suppresses a false edge.

// File: rtl/intr_req_gate_pkg.sv
package intr_req_gate_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // bit 1 selects transition sensing, bit 0 the active value
  function automatic logic sense_is_edge(input sense_e m);
    return m[1];
  endfunction

  function automatic logic sense_active_val(input sense_e m);
    return m[0];
  endfunction

  // request event from the synchronized sample and its one-cycle history
  function automatic logic sense_event(input sense_e m, input logic cur, input logic prev);
    logic act;
    act = sense_active_val(m);
    if (sense_is_edge(m)) return (cur == act) && (prev != act);
    else                  return (cur == act);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_condition.sv
module irq_condition
  import intr_req_gate_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   cur,
  output logic   armed,
  output logic   evt
);
  localparam int CW = $clog2(ARM_CYCLES + 1);

  logic          prev_q;
  logic [CW-1:0] arm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          arm_cnt <= '0;
    else if (arm_cnt != CW'(ARM_CYCLES)) arm_cnt <= arm_cnt + 1'b1;
  end

  assign armed = (arm_cnt == CW'(ARM_CYCLES));
  assign evt   = armed && sense_event(mode, cur, prev_q);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // a fresh event wins over the acknowledge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // any clearing cause wins over a set in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
endmodule

// File: rtl/intr_req_gate.sv
module intr_req_gate
  import intr_req_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_raw,
  input  logic [1:0] sense_mode,
  input  logic       ei_strobe,
  input  logic       di_strobe,
  input  logic       reti_strobe,
  input  logic       ack_in,
  output logic       pend_o,
  output logic       dev_ack_o
);
  localparam int ARM_CYCLES = SYNC_STAGES + 1;

  sense_e mode;
  logic   line_s;
  logic   armed;
  logic   set_evt;
  logic   ack_take;
  logic   req_q;
  logic   en_q;
  logic   en_set;
  logic   en_clr;

  assign mode = sense_e'(sense_mode);

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(irq_raw),
    .q_sync (line_s)
  );

  irq_condition #(.ARM_CYCLES(ARM_CYCLES)) u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode),
    .cur  (line_s),
    .armed(armed),
    .evt  (set_evt)
  );

  irq_req_latch u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_evt),
    .clr_i(ack_take),
    .q    (req_q)
  );

  assign en_set = ei_strobe | reti_strobe;
  assign en_clr = di_strobe | ack_take;

  irq_enable_ff u_en (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(en_set),
    .clr_i(en_clr),
    .q    (en_q)
  );

  assign pend_o    = req_q & en_q;
  assign ack_take  = ack_in & pend_o;
  assign dev_ack_o = ack_take;
endmodule

// File: rtl/intr_req_gate_chk.sv
module intr_req_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sense_mode,
  input logic       ei_strobe,
  input logic       di_strobe,
  input logic       reti_strobe,
  input logic       ack_in,
  input logic       pend_o,
  input logic       set_evt,
  input logic       ack_take,
  input logic       req_q,
  input logic       en_q,
  input logic       armed
);
  // R1: nothing is recognised before the history is armed
  a_r1_no_event_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !req_q);

  // R3: the latch holds until a taken acknowledge
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_take) |=> req_q);

  // R5: a disable strobe clears the enable
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    di_strobe |=> !en_q);

  // R6: enable or return strobe sets the enable when nothing clears it
  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((ei_strobe || reti_strobe) && !di_strobe && !ack_take) |=> en_q);

  // R7: an acknowledge with nothing pending leaves the enable alone
  a_r7_idle_ack_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !pend_o && !di_strobe && !ei_strobe && !reti_strobe) |=> $stable(en_q));

  // R8: a taken acknowledge drops the enable and the pending output
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (!en_q && !pend_o));

  // R9: level mode with the level still present re-sets the latch
  a_r9_level_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_mode[1] && ack_take && set_evt) |=> req_q);

  // R10: edge mode needs a new edge after acknowledge
  a_r10_edge_needs_new: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode[1] && ack_take && !set_evt) |=> !req_q);
endmodule

bind intr_req_gate intr_req_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sense_mode (sense_mode),
  .ei_strobe  (ei_strobe),
  .di_strobe  (di_strobe),
  .reti_strobe(reti_strobe),
  .ack_in     (ack_in),
  .pend_o     (pend_o),
  .set_evt    (set_evt),
  .ack_take   (ack_take),
  .req_q      (req_q),
  .en_q       (en_q),
  .armed      (armed)
);

// File: tb/intr_req_gate_tb.sv
`timescale 1ns/1ps
module intr_req_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_raw = 1'b0;
  logic [1:0] sense_mode = 2'b00;
  logic       ei_strobe = 1'b0;
  logic       di_strobe = 1'b0;
  logic       reti_strobe = 1'b0;
  logic       ack_in = 1'b0;
  logic       pend_o;
  logic       dev_ack_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_req_gate u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_raw    (irq_raw),
    .sense_mode (sense_mode),
    .ei_strobe  (ei_strobe),
    .di_strobe  (di_strobe),
    .reti_strobe(reti_strobe),
    .ack_in     (ack_in),
    .pend_o     (pend_o),
    .dev_ack_o  (dev_ack_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d t=%0t actual=%b expected=%b", req, sense_mode, $time, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic line);
    sense_mode = m;
    irq_raw    = line;
    rst_n      = 1'b0;
    wait_neg(3);
    chk("R1 pend in reset", pend_o, 1'b0);
    chk("R1 dev_ack in reset", dev_ack_o, 1'b0);
    rst_n = 1'b1;
    wait_neg(8);
  endtask

  task automatic pulse_ei();   ei_strobe = 1'b1;   wait_neg(1); ei_strobe = 1'b0;   endtask
  task automatic pulse_di();   di_strobe = 1'b1;   wait_neg(1); di_strobe = 1'b0;   endtask
  task automatic pulse_reti(); reti_strobe = 1'b1; wait_neg(1); reti_strobe = 1'b0; endtask

  task automatic do_ack(input logic exp_dev);
    ack_in = 1'b1;
    #1;
    chk("R7 dev_ack follows pend", dev_ack_o, exp_dev);
    wait_neg(1);
    ack_in = 1'b0;
  endtask

  task automatic run_mode(input logic [1:0] m);
    logic act_v;
    logic idle_v;
    logic is_edge;
    act_v   = m[0];
    idle_v  = ~m[0];
    is_edge = m[1];

    do_reset(m, idle_v);
    chk("R1 no request after reset", pend_o, 1'b0);
    pulse_ei();
    chk("R1 idle line gives nothing", pend_o, 1'b0);

    // R2: latency of three clock edges
    irq_raw = act_v;
    wait_neg(2);
    chk("R2 not yet at second edge", pend_o, 1'b0);
    wait_neg(1);
    chk("R2 pending at third edge", pend_o, 1'b1);

    // R3: line back to idle, latch keeps it
    irq_raw = idle_v;
    wait_neg(4);
    chk("R3 latched after line idle", pend_o, 1'b1);

    // R8: acknowledge clears latch and enable
    do_ack(1'b1);
    chk("R8 pend drops after ack", pend_o, 1'b0);
    pulse_ei();
    chk("R8 latch was cleared", pend_o, 1'b0);

    // R9/R10: acknowledge with line still active
    irq_raw = act_v;
    wait_neg(4);
    chk("R2 second request seen", pend_o, 1'b1);
    do_ack(1'b1);
    chk("R8 enable cleared by ack", pend_o, 1'b0);
    pulse_reti();
    if (is_edge) chk("R10 no re-trigger without edge", pend_o, 1'b0);
    else         chk("R9 level re-sets latch", pend_o, 1'b1);

    // R11: opposite transition / inactive level
    irq_raw = idle_v;
    wait_neg(4);
    if (is_edge) chk("R11 opposite edge ignored", pend_o, 1'b0);
    else begin
      chk("R3 level request still latched", pend_o, 1'b1);
      do_ack(1'b1);
      pulse_reti();
    end
    wait_neg(3);
    chk("R11 inactive line sets nothing", pend_o, 1'b0);

    // R4: request while disabled is kept
    pulse_di();
    irq_raw = act_v;
    wait_neg(4);
    chk("R4 gated while disabled", pend_o, 1'b0);
    do_ack(1'b0);
    pulse_ei();
    chk("R4 appears on enable", pend_o, 1'b1);
    chk("R7 idle ack kept latch", pend_o, 1'b1);
    pulse_di();
    chk("R5 disable clears", pend_o, 1'b0);
    ei_strobe = 1'b1; di_strobe = 1'b1;
    wait_neg(1);
    ei_strobe = 1'b0; di_strobe = 1'b0;
    chk("R6 clear wins over set", pend_o, 1'b0);
    pulse_reti();
    chk("R6 reti sets enable", pend_o, 1'b1);
    irq_raw = idle_v;
    do_ack(1'b1);
  endtask

  initial begin
    wait_neg(2);
    for (int m = 0; m < 4; m++) run_mode(m[1:0]);
    // R1: rising mode with line high through reset: no false edge
    do_reset(2'b11, 1'b1);
    pulse_ei();
    wait_neg(4);
    chk("R1 no false edge after reset", pend_o, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule